// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Requester

This block lets one peripheral channel request processor service on a bus that has a single interrupt acknowledge chain. The channel raises an internal request flag each time its ready line rises (a count overflow, a device attention signal and a missing-reply fault all surface as ready rising). When the interrupt enable is also set, the block asserts its request output.

The processor answers with its data-in strobe and then an acknowledge that enters the block at `ack_in`. On the first cycle the acknowledge is seen, the block decides once whether it is the requester. If it is, it takes the cycle. It drives its vector onto the data lines, gives a reply for as long as the data-in strobe stays high, and drops its request. If it is not, it forwards the acknowledge to the next device on `ack_out` until the acknowledge goes away. A served cycle ends only after the processor has dropped both the strobe and the acknowledge.

The vector is a static setting. Its two low bits are always zero and the normal setting is octal 124.

The controller has three states:
- IDLE: no acknowledge in progress.
- PASS: an acknowledge arrived while not requesting, and it is being forwarded.
- SERVE: an acknowledge arrived while requesting, and the vector is being driven.

The controller has four transitions:
- IDLE→SERVE: `ack_in` high while `irq` is high.
- IDLE→PASS: `ack_in` high while `irq` is low.
- PASS→IDLE: `ack_in` low.
- SERVE→IDLE: both `ack_in` and `din` low.

`init` forces IDLE from any state.

Top module: `irq_chain_requester`

## Requirements
- R1: `irq` is high exactly when `int_en`, `ready` and the request flag are all high. The flag is set at the clock edge that follows a cycle in which `ready` is high after being low in the previous cycle.
- R2: Keeping `ready` high does not set the flag again. After a request has been served, `irq` stays low until `ready` falls and rises again.
- R3: If `ack_in` is seen high in IDLE while `irq` is high, then from the next cycle the block is in SERVE. In SERVE, `vec_oe` is high, `reply` equals `din`, and `irq` is low because the flag is cleared.
- R4: If `ack_in` is seen high in IDLE while `irq` is low, then from the next cycle the block is in PASS. In PASS, `ack_out` equals `ack_in`. `vec_oe` and `reply` stay low. Outside PASS, `ack_out` is low.
- R5: SERVE ends at the first edge at which both `din` and `ack_in` are low. After that edge, `vec_oe` and `reply` are low.
- R6: While `vec_oe` is high, `vec_data` equals the vector setting `vec_sel` shifted left by two bits, with zero in bits 1:0 and zero in the upper bits. The normal setting is `vec_sel` = 21, giving octal 124. While `vec_oe` is low, `vec_data` is all zero.
- R7: The forward-or-serve choice is held for the whole acknowledge. A request that appears during PASS is not served by that acknowledge. It stays pending and is served by the next acknowledge.
- R8: `init` high at an edge clears the request flag and returns the block to IDLE. From the next cycle, `irq`, `vec_oe` and `reply` are low. Active-low `rst_n` does the same asynchronously.
- R9: Taking `int_en` low withdraws `irq` in the same cycle but keeps the flag. Taking `int_en` high again restores `irq` if `ready` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous bus initialise |
| ready | input | 1 | Channel ready level |
| int_en | input | 1 | Interrupt enable |
| ack_in | input | 1 | Acknowledge arriving from the chain |
| din | input | 1 | Processor data-in strobe |
| vec_sel | input | 7 | Static vector setting (vector bits 8:2) |
| irq | output | 1 | Interrupt request |
| ack_out | output | 1 | Acknowledge forwarded down the chain |
| vec_oe | output | 1 | Vector drive enable for the data lines |
| vec_data | output | 16 | Vector value, zero when not driving |
| reply | output | 1 | Reply to the processor |

## Verification
The bench raises a request while an acknowledge is already being forwarded. A design that re-decided the choice mid-acknowledge would grab the vector cycle and split the chain. The bench also keeps `ready` high across a served request. A level-sensitive flag would raise a second, spurious interrupt. The bench drops `din` before `ack_in` and asserts `init` in the middle of SERVE. A design that released early would stop driving the vector while the processor still held its acknowledge. A design that ignored `init` would keep replying. Finally, the bench toggles `int_en` over a pending request. A design that cleared the flag on disable would lose the interrupt.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PASS  = 2'd1,
        S_SERVE = 2'd2
    } ack_state_t;
endpackage

// File: rtl/irq_req_flag.sv
module irq_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic ready,
    input  logic int_en,
    input  logic take,
    output logic irq
);
    logic ready_q;
    logic pend_q;
    logic ready_rise;

    assign ready_rise = ready && !ready_q;
    assign irq        = int_en && pend_q && ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            ready_q <= ready;
            if (init || take)
                pend_q <= 1'b0;
            else if (ready_rise)
                pend_q <= 1'b1;
        end
    end

    // R1: request implies both qualifiers present
    p_irq_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready && int_en));
    // R8: init leaves no request behind
    p_init_clears_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !irq);
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic ack_in,
    input  logic din,
    input  logic irq,
    output logic take,
    output logic ack_out,
    output logic vec_oe,
    output logic reply
);
    ack_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (init) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  if (ack_in) state_d = irq ? S_SERVE : S_PASS;
                S_PASS:  if (!ack_in) state_d = S_IDLE;
                S_SERVE: if (!ack_in && !din) state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        take    = 1'b0;
        ack_out = 1'b0;
        vec_oe  = 1'b0;
        reply   = 1'b0;
        unique case (state_q)
            S_IDLE:  take    = ack_in && irq && !init;
            S_PASS:  ack_out = ack_in;
            S_SERVE: begin
                vec_oe = 1'b1;
                reply  = din;
            end
            default: ;
        endcase
    end

    // R4: never forward and serve at once
    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_out && vec_oe));
    // R5: release once both processor strobes are gone
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && !ack_in && !din) |=> !vec_oe);
    // R7: a held acknowledge being forwarded never turns into a serve
    p_no_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && ack_in) |=> !vec_oe);
    // R8: init ends any reply
    p_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!vec_oe && !reply));
endmodule

// File: rtl/irq_vec_fmt.sv
module irq_vec_fmt #(
    parameter int VEC_W = 16,
    parameter int SEL_W = 7
) (
    input  logic [SEL_W-1:0] vec_sel,
    input  logic             vec_oe,
    output logic [VEC_W-1:0] vec_data
);
    localparam int PAD_W = VEC_W - SEL_W - 2;
    logic [VEC_W-1:0] vec_full;

    generate
        if (PAD_W > 0) begin : g_pad
            assign vec_full = {{PAD_W{1'b0}}, vec_sel, 2'b00};
        end else begin : g_nopad
            assign vec_full = {vec_sel[VEC_W-3:0], 2'b00};
        end
    endgenerate

    assign vec_data = vec_oe ? vec_full : '0;
endmodule

// File: rtl/irq_chain_requester.sv
module irq_chain_requester #(
    parameter int VEC_W = 16,
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             ready,
    input  logic             int_en,
    input  logic             ack_in,
    input  logic             din,
    input  logic [SEL_W-1:0] vec_sel,
    output logic             irq,
    output logic             ack_out,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec_data,
    output logic             reply
);
    logic take;

    irq_req_flag u_flag (
        .clk(clk), .rst_n(rst_n), .init(init), .ready(ready),
        .int_en(int_en), .take(take), .irq(irq)
    );

    irq_ack_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .init(init), .ack_in(ack_in), .din(din),
        .irq(irq), .take(take), .ack_out(ack_out), .vec_oe(vec_oe),
        .reply(reply)
    );

    irq_vec_fmt #(.VEC_W(VEC_W), .SEL_W(SEL_W)) u_fmt (
        .vec_sel(vec_sel), .vec_oe(vec_oe), .vec_data(vec_data)
    );

    // R3: entering service drops the request
    p_take_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> !irq);
    // R6: low vector bits never driven high
    p_vec_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (vec_data[1:0] == 2'b00));
endmodule

// File: tb/tb_irq_chain_requester.sv
`timescale 1ns/1ps
module tb_irq_chain_requester;
    localparam int VEC_W = 16;
    localparam int SEL_W = 7;

    typedef struct {
        string            tag;
        logic             irq;
        logic             ack_out;
        logic             oe;
        logic             reply;
        logic [VEC_W-1:0] vec;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init = 1'b0, ready = 1'b0, int_en = 1'b0, ack_in = 1'b0, din = 1'b0;
    logic [SEL_W-1:0] vec_sel = 7'd21;
    logic irq, ack_out, vec_oe, reply;
    logic [VEC_W-1:0] vec_data;

    int n_run = 0;
    int n_fail = 0;
    exp_t sb[$];
    bit done = 0;

    always #4 clk = ~clk;

    irq_chain_requester #(.VEC_W(VEC_W), .SEL_W(SEL_W)) dut (
        .clk(clk), .rst_n(rst_n), .init(init), .ready(ready), .int_en(int_en),
        .ack_in(ack_in), .din(din), .vec_sel(vec_sel), .irq(irq),
        .ack_out(ack_out), .vec_oe(vec_oe), .vec_data(vec_data), .reply(reply)
    );

    // monitor: compares mid-cycle against queued expectations
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (irq !== e.irq || ack_out !== e.ack_out || vec_oe !== e.oe ||
                reply !== e.reply || vec_data !== e.vec) begin
                n_fail++;
                $display("FAIL %s: got irq=%b ack_out=%b oe=%b reply=%b vec=%h exp irq=%b ack_out=%b oe=%b reply=%b vec=%h",
                         e.tag, irq, ack_out, vec_oe, reply, vec_data,
                         e.irq, e.ack_out, e.oe, e.reply, e.vec);
            end
        end
    end

    // driver: set inputs just after an edge, queue expected outputs
    task automatic step(input logic i_init, input logic i_rdy, input logic i_ie,
                        input logic i_ack, input logic i_din, input string tag,
                        input logic e_irq, input logic e_ao, input logic e_oe,
                        input logic e_rep, input logic [VEC_W-1:0] e_vec);
        exp_t e;
        @(posedge clk);
        #1;
        init = i_init; ready = i_rdy; int_en = i_ie; ack_in = i_ack; din = i_din;
        e.tag = tag; e.irq = e_irq; e.ack_out = e_ao; e.oe = e_oe;
        e.reply = e_rep; e.vec = e_vec;
        sb.push_back(e);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got hang exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        localparam logic [15:0] V124 = 16'o124;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        //      init rdy ie ack din tag           irq ao oe rep vec
        step(0,0,0,0,0, "R8 reset",        0,0,0,0,16'h0);
        step(0,1,1,0,0, "R1 rise pending", 0,0,0,0,16'h0);
        step(0,1,1,0,0, "R1 request",      1,0,0,0,16'h0);
        step(0,1,1,0,1, "R1 din only",     1,0,0,0,16'h0);
        step(0,1,1,1,1, "R3 ack seen",     1,0,0,0,16'h0);
        step(0,1,1,1,1, "R3 R6 serve",     0,0,1,1,V124);
        step(0,1,1,1,0, "R3 reply=din",    0,0,1,0,V124);
        step(0,1,1,0,0, "R5 last serve",   0,0,1,0,V124);
        step(0,1,1,0,0, "R2 R5 released",  0,0,0,0,16'h0);
        step(0,1,1,0,1, "R4 idle",         0,0,0,0,16'h0);
        step(0,1,1,1,1, "R4 ack seen",     0,0,0,0,16'h0);
        step(0,1,1,1,1, "R4 forward",      0,1,0,0,16'h0);
        step(0,0,1,1,1, "R4 fwd rdy low",  0,1,0,0,16'h0);
        step(0,1,1,1,1, "R7 rise in pass", 0,1,0,0,16'h0);
        step(0,1,1,1,1, "R7 no capture",   1,1,0,0,16'h0);
        step(0,1,1,0,0, "R4 ack drop",     1,0,0,0,16'h0);
        step(0,1,1,0,1, "R7 pending",      1,0,0,0,16'h0);
        step(0,1,1,1,1, "R7 next ack",     1,0,0,0,16'h0);
        step(0,1,1,1,1, "R7 served",       0,0,1,1,V124);
        step(0,1,1,0,0, "R5 end",          0,0,1,0,V124);
        step(0,0,1,0,0, "R5 idle",         0,0,0,0,16'h0);
        step(0,1,1,0,0, "R9 rise",         0,0,0,0,16'h0);
        step(0,1,1,0,0, "R9 request",      1,0,0,0,16'h0);
        step(0,1,0,0,0, "R9 withdrawn",    0,0,0,0,16'h0);
        step(0,1,1,0,0, "R9 restored",     1,0,0,0,16'h0);
        step(1,1,1,0,0, "R8 init edge",    1,0,0,0,16'h0);
        step(0,1,1,0,0, "R8 flag cleared", 0,0,0,0,16'h0);
        step(0,0,1,0,0, "R8 prep",         0,0,0,0,16'h0);
        step(0,1,1,0,0, "R8 rise",         0,0,0,0,16'h0);
        step(0,1,1,1,1, "R8 ack",          1,0,0,0,16'h0);
        step(0,1,1,1,1, "R8 serving",      0,0,1,1,V124);
        step(1,1,1,1,1, "R8 init serve",   0,0,1,1,V124);
        step(0,1,1,1,1, "R8 reply gone",   0,0,0,0,16'h0);
        step(0,1,1,0,0, "R8 after",        0,0,0,0,16'h0);
        vec_sel = 7'h55;
        step(0,0,1,0,0, "R6 prep",         0,0,0,0,16'h0);
        step(0,1,1,0,0, "R6 rise",         0,0,0,0,16'h0);
        step(0,1,1,1,1, "R6 ack",          1,0,0,0,16'h0);
        step(0,1,1,1,1, "R6 alt vector",   0,0,1,1,16'h0154);
        step(0,1,1,0,0, "R6 end",          0,0,1,0,16'h0154);
        step(0,1,1,0,0, "R6 zero idle",    0,0,0,0,16'h0);
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule